// File: doc/BRIEF.md
# Regulator Tap Stepping Controller

This block tracks the signed tap position of one single-phase step voltage regulator and decides when and how far to move it. It keeps an expected output voltage that acts as its reference. When a valid voltage sample differs from that reference by more than one tap's worth of voltage, the sample becomes the new reference. The controller then works out how many taps separate that sample from the target voltage supplied by an upstream estimator.

The step count is found by repeated subtraction, and a remainder of at least half a step rounds the count up. Before any motor command is issued, the planned move is checked against a tap range of ±16 and a programmable voltage band. Each failed check lowers the plan by one step and checks it again. An accepted plan is carried out as single-step raise or lower pulses of programmable width, with a programmable settle gap after each one. The tap position and expected voltage move by one step per pulse, and the controller then returns to watching samples.

Top module: `tap_step_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) sets the tap position to 0, the expected voltage to 0, clears raise, lower and blocked, and leaves the block idle (`busy_o` low).
- R2: While idle, a sample with `smp_vld` high starts an evaluation only when |`smp_v` − `vexp_o`| is strictly greater than `step_v`. A sample exactly one step away does nothing. A triggering sample is copied into `vexp_o`.
- R3: The planned count is floor(|`tgt_v` − `smp_v`| / `step_v`), plus one when twice the remainder is at least `step_v`.
- R4: When `tgt_v` is above the sample, the move is in the raise direction and each step adds 1 to the tap. Otherwise the move is in the lower direction and each step subtracts 1.
- R5: Each step is one pulse on `raise_o` or `lower_o`, lasting max(`pulse_cyc`,1) cycles. Each pulse is followed by max(`settle_cyc`,1) idle cycles. The tap changes by exactly 1 per pulse.
- R6: A plan is cut by one step while the resulting tap would lie outside −16..+16. The tap never leaves that range.
- R7: A plan is cut by one step while the predicted output, `smp_v` ± count·`step_v`, lies outside [`band_lo`, `band_hi`].
- R8: If cutting brings the plan to zero, `blocked_o` is high for exactly one cycle and no pulse is issued. A plan that was zero from the start returns to idle without `blocked_o`.
- R9: After a move, `vexp_o` equals the triggering sample ± (steps taken)·`step_v`, and it serves as the reference for later samples.
- R10: `raise_o` and `lower_o` are never high in the same cycle.
- R11: Samples that arrive while `busy_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_v | input | VW | Sampled output voltage code |
| tgt_v | input | VW | Target output voltage from estimator |
| step_v | input | VW | Voltage change of one tap |
| band_lo | input | VW | Lowest allowed predicted output |
| band_hi | input | VW | Highest allowed predicted output |
| pulse_cyc | input | PW | Motor pulse width in cycles |
| settle_cyc | input | PW | Settle gap after each pulse in cycles |
| raise_o | output | 1 | Raise-one-tap motor pulse |
| lower_o | output | 1 | Lower-one-tap motor pulse |
| blocked_o | output | 1 | One-cycle flag: restrictions cancelled the move |
| busy_o | output | 1 | Evaluation or move in progress |
| tap_o | output | TW (signed) | Tracked tap position |
| vexp_o | output | VW | Expected output voltage / reference |

## Verification
A bad step count shows up as the wrong number of motor pulses, and the tap and expected voltage outputs go wrong by the same amount once the move ends. A reference that is corrupted shows up on the next sample: a change of exactly one step would start a move, or a large change would be missed. A direction flag that is wrong drives the opposite pulse on the very first pulse cycle. A restriction check that is wrong shows up as a tap past ±16, a voltage outside the band, or a missing one-cycle blocked flag, all by the end of the evaluation.

// File: rtl/tap_step_ctrl.sv
module tap_step_ctrl #(
  parameter int VW      = 12,
  parameter int TW      = 6,
  parameter int CW      = 6,
  parameter int PW      = 8,
  parameter int TAP_LIM = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic [VW-1:0]        smp_v,
  input  logic [VW-1:0]        tgt_v,
  input  logic [VW-1:0]        step_v,
  input  logic [VW-1:0]        band_lo,
  input  logic [VW-1:0]        band_hi,
  input  logic [PW-1:0]        pulse_cyc,
  input  logic [PW-1:0]        settle_cyc,
  output logic                 raise_o,
  output logic                 lower_o,
  output logic                 blocked_o,
  output logic                 busy_o,
  output logic signed [TW-1:0] tap_o,
  output logic [VW-1:0]        vexp_o
);
  localparam int EW  = VW + CW + 2;
  localparam int PEW = TW + CW + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic signed [PEW-1:0] PLIM = PEW'(TAP_LIM);

  typedef enum logic [2:0] {MON, CALC, CHK, PULSE, SETTLE} st_t;
  st_t st;

  logic          up, cut;
  logic [VW-1:0] rem;
  logic [CW-1:0] cnt;
  logic [PW-1:0] tmr;

  wire [VW-1:0] dev  = (smp_v > vexp_o) ? smp_v - vexp_o : vexp_o - smp_v;
  wire [VW-1:0] gap  = (tgt_v > smp_v) ? tgt_v - smp_v : smp_v - tgt_v;
  wire          trig = smp_vld && (dev > step_v);
  wire          more = (rem >= step_v) && (cnt != CMAX);
  wire          half = {rem, 1'b0} >= {1'b0, step_v};

  logic [EW-1:0]          dv;
  logic signed [EW-1:0]   v_nx;
  logic signed [PEW-1:0]  p_nx, pc;
  logic                   bad;

  always_comb begin
    dv   = EW'(cnt) * EW'(step_v);
    v_nx = up ? signed'(EW'(vexp_o)) + signed'(dv) : signed'(EW'(vexp_o)) - signed'(dv);
    pc   = signed'(PEW'(cnt));
    p_nx = up ? PEW'(tap_o) + pc : PEW'(tap_o) - pc;
    bad  = (p_nx > PLIM) || (p_nx < -PLIM) ||
           (v_nx > signed'(EW'(band_hi))) || (v_nx < signed'(EW'(band_lo)));
  end

  assign raise_o = (st == PULSE) && up;
  assign lower_o = (st == PULSE) && !up;
  assign busy_o  = (st != MON);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= MON; tap_o <= '0; vexp_o <= '0; cnt <= '0; rem <= '0;
      tmr <= '0; up <= 1'b0; cut <= 1'b0; blocked_o <= 1'b0;
    end else begin
      blocked_o <= 1'b0;
      case (st)
        MON: if (trig) begin
          vexp_o <= smp_v;
          up     <= tgt_v > smp_v;
          rem    <= gap;
          cnt    <= '0;
          cut    <= 1'b0;
          st     <= CALC;
        end
        CALC: if (more) begin
          rem <= rem - step_v;
          cnt <= cnt + 1'b1;
        end else begin
          if (half && cnt != CMAX) cnt <= cnt + 1'b1;
          st <= CHK;
        end
        CHK: if (cnt == '0) begin
          blocked_o <= cut;
          st        <= MON;
        end else if (bad) begin
          cnt <= cnt - 1'b1;
          cut <= 1'b1;
        end else begin
          tmr <= pulse_cyc;
          st  <= PULSE;
        end
        PULSE: if (tmr <= PW'(1)) begin
          tap_o  <= up ? tap_o + 1'b1 : tap_o - 1'b1;
          vexp_o <= up ? vexp_o + step_v : vexp_o - step_v;
          cnt    <= cnt - 1'b1;
          tmr    <= settle_cyc;
          st     <= SETTLE;
        end else tmr <= tmr - 1'b1;
        SETTLE: if (tmr <= PW'(1)) begin
          tmr <= pulse_cyc;
          st  <= (cnt == '0) ? MON : PULSE;
        end else tmr <= tmr - 1'b1;
        default: st <= MON;
      endcase
    end
  end

  AST_RST_STATE: assert property (@(posedge clk) rst |=> (tap_o == '0 && !busy_o && !blocked_o)); // R1
  AST_TRIG_ONLY: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> $past(smp_vld)); // R2
  AST_TAP_UNIT:  assert property (@(posedge clk) disable iff (rst)
                   (tap_o != $past(tap_o)) |->
                   (($past(raise_o) && tap_o == $past(tap_o) + 1'b1) ||
                    ($past(lower_o) && tap_o == $past(tap_o) - 1'b1))); // R5
  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (rst)
                   (PEW'(tap_o) <= PLIM) && (PEW'(tap_o) >= -PLIM)); // R6
  AST_BLOCK_ONE: assert property (@(posedge clk) disable iff (rst) blocked_o |=> !blocked_o); // R8
  AST_NO_BOTH:   assert property (@(posedge clk) disable iff (rst) !(raise_o && lower_o)); // R10
endmodule

// File: tb/tap_step_ctrl_tb.sv
module tap_step_ctrl_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0;
  logic [11:0] smp_v = '0, tgt_v = '0, step_v = 12'd16, band_lo = 12'd800, band_hi = 12'd1200;
  logic [7:0]  pulse_cyc = 8'd3, settle_cyc = 8'd2;
  logic raise_o, lower_o, blocked_o, busy_o;
  logic signed [5:0] tap_o;
  logic [11:0] vexp_o;

  int checks = 0, errors = 0;
  int r_cyc = 0, l_cyc = 0, b_cyc = 0, n_pulse = 0, gap = 0, last_gap = 0, ovl = 0;
  bit prev_act = 1'b0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tap_step_ctrl u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_v(smp_v), .tgt_v(tgt_v),
    .step_v(step_v), .band_lo(band_lo), .band_hi(band_hi),
    .pulse_cyc(pulse_cyc), .settle_cyc(settle_cyc),
    .raise_o(raise_o), .lower_o(lower_o), .blocked_o(blocked_o),
    .busy_o(busy_o), .tap_o(tap_o), .vexp_o(vexp_o)
  );

  always @(negedge clk) begin
    if (raise_o) r_cyc++;
    if (lower_o) l_cyc++;
    if (blocked_o) b_cyc++;
    if (raise_o && lower_o) ovl++;
    if ((raise_o || lower_o) && !prev_act) begin n_pulse++; last_gap = gap; end
    gap = (raise_o || lower_o) ? 0 : gap + 1;
    prev_act = raise_o || lower_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    r_cyc = 0; l_cyc = 0; b_cyc = 0; n_pulse = 0; last_gap = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 2000) begin @(negedge clk); n++; end
    chk(!busy_o, "R5 move finishes", n, 0);
  endtask

  task automatic send(input int s, input int t);
    clr();
    @(negedge clk); smp_vld = 1'b1; smp_v = 12'(s); tgt_v = 12'(t);
    @(negedge clk); smp_vld = 1'b0;
    wait_idle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(tap_o == 0, "R1 tap", tap_o, 0);
    chk(vexp_o == 0 && !busy_o, "R1 vexp/busy", vexp_o, 0);
    chk(!raise_o && !lower_o && !blocked_o, "R1 outputs", raise_o + lower_o, 0);
  endtask

  task automatic t_prime_and_deadband();
    send(1000, 1000);
    chk(vexp_o == 1000, "R2 sample loaded", vexp_o, 1000);
    chk(b_cyc == 0 && n_pulse == 0, "R8 zero plan is not blocked", b_cyc, 0);
    send(1016, 1200);
    chk(vexp_o == 1000 && n_pulse == 0, "R2 one step away ignored", vexp_o, 1000);
    send(984, 800);
    chk(vexp_o == 1000 && n_pulse == 0, "R2 one step below ignored", vexp_o, 1000);
  endtask

  task automatic t_raise_round_up();
    clr();
    @(negedge clk); smp_vld = 1'b1; smp_v = 12'd1017; tgt_v = 12'd1057;
    @(negedge clk); smp_vld = 1'b0;
    repeat (8) @(negedge clk);
    smp_vld = 1'b1; smp_v = 12'd500; tgt_v = 12'd500;
    @(negedge clk); smp_vld = 1'b0;
    wait_idle(); @(negedge clk);
    chk(n_pulse == 3, "R3 40/16 rounds to 3", n_pulse, 3);
    chk(r_cyc == 9 && l_cyc == 0, "R4 raise pulses", r_cyc, 9);
    chk(last_gap == 2, "R5 settle gap", last_gap, 2);
    chk(tap_o == 3, "R4 tap raised", tap_o, 3);
    chk(vexp_o == 1065, "R9 expected voltage, R11 busy sample ignored", vexp_o, 1065);
  endtask

  task automatic t_lower_round_down();
    send(1040, 1017);
    chk(l_cyc == 3 && r_cyc == 0, "R4 single lower pulse", l_cyc, 3);
    chk(n_pulse == 1, "R3 23/16 rounds to 1", n_pulse, 1);
    chk(tap_o == 2 && vexp_o == 1024, "R9 after lower", vexp_o, 1024);
  endtask

  task automatic t_tap_limit();
    band_hi = 12'd4095;
    send(1000, 1320);
    chk(n_pulse == 14, "R6 plan cut at tap limit", n_pulse, 14);
    chk(tap_o == 16 && vexp_o == 1224, "R6 tap at +16", tap_o, 16);
    send(1250, 1300);
    chk(b_cyc == 1 && n_pulse == 0, "R8 blocked one cycle at limit", b_cyc, 1);
    chk(tap_o == 16 && vexp_o == 1250, "R8 no move when blocked", tap_o, 16);
    band_hi = 12'd1200;
  endtask

  task automatic t_band();
    do_reset();
    send(1000, 1000);
    send(1100, 1300);
    chk(n_pulse == 6 && tap_o == 6, "R7 upper band cut", n_pulse, 6);
    chk(vexp_o == 1196, "R7 expected within band", vexp_o, 1196);
    send(830, 700);
    chk(n_pulse == 1 && l_cyc == 3 && tap_o == 5, "R7 lower band cut", n_pulse, 1);
    chk(vexp_o == 814, "R9 after band-limited lower", vexp_o, 814);
    band_hi = 12'd1180;
    send(1170, 1250);
    chk(b_cyc == 1 && n_pulse == 0 && tap_o == 5, "R8 blocked by band", b_cyc, 1);
    band_hi = 12'd1200;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prime_and_deadband();
    t_raise_round_up();
    t_lower_round_down();
    t_tap_limit();
    t_band();
    chk(ovl == 0, "R10 raise and lower exclusive", ovl, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule